// File: doc/BRIEF.md
# Warp Shared-Memory Bank Conflict Arbiter

This block accepts one batch of up to 32 lane requests for a banked scratch memory and serves them in as few cycles as the bank layout allows. Each lane can be enabled or not, and carries a word address, a write flag and write data. A word's bank is its word address modulo the bank count, and the remaining upper address bits select a row inside that bank. Every bank is single-ported. In each cycle a bank serves exactly one row. Lanes that target different banks are served together. Lanes that target different rows of one bank are spread over extra cycles. All lanes that name the same word are served in a single cycle, so a common read is broadcast to all of them.

The request side is a valid/ready stream. `req_ready` is high only while the block is idle. A batch is taken on a cycle where both `req_valid` and `req_ready` are high. From then until its response has been accepted, `req_ready` stays low and `req_valid` is ignored. The response side is also a valid/ready stream. `rsp_valid` rises for one batch and carries per-lane read data and the number of service cycles used. It holds that payload steady until `rsp_ready` is sampled high. The block therefore applies back-pressure upstream for as long as the downstream side stalls. The bank storage is a register array that clears to zero on reset.

Top module: `smem_conflict_arb`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every memory word reads as zero.
- R2: A batch whose enabled lanes all fall in different banks (bank = address bits [4:0]) completes with `rsp_cycles` = 1.
- R3: `rsp_cycles` equals the largest count of distinct word addresses that the enabled lanes place in any one bank. For example, lane i reading word 2i+k gives 2, and 32 distinct rows of one bank give 32.
- R4: Enabled lanes that read one identical address are served in one cycle, and each of them returns that word.
- R5: A write stores its data. A later batch that reads the same address returns that data.
- R6: When several lanes of one batch write the same address, the data of the highest-numbered of those lanes is stored.
- R7: A read and a write of the same address in one batch are served in the same cycle. The read returns the value held before the batch.
- R8: Disabled lanes and write lanes return zero read data. A batch with no lane enabled completes with `rsp_cycles` = 0 and writes nothing.
- R9: `req_ready` is low from the cycle after an accepted batch until its response is taken. `req_valid` during that time has no effect on the memory.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_rdata` and `rsp_cycles` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Batch offered |
| req_ready | output | 1 | Block idle and able to take a batch |
| req_lane_en | input | 32 | Per-lane enable |
| req_we | input | 32 | Per-lane write flag (1 = write) |
| req_addr | input | 320 | Per-lane word address, lane i at bits [10i+9:10i] |
| req_wdata | input | 1024 | Per-lane write data, lane i at bits [32i+31:32i] |
| rsp_valid | output | 1 | Batch fully served, payload valid |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_rdata | output | 1024 | Per-lane read data, lane i at bits [32i+31:32i] |
| rsp_cycles | output | 6 | Service cycles the batch needed |

## Verification
Several address patterns are applied to the design, and each one separates a different failure.
- Unit-stride batches place every lane in its own bank. They expose any needless serialization, and they show whether bank selection and row storage are correct.
- Stride-2 batches and batches of 32 rows in one bank each have a known conflict degree. They show whether the cycle count follows the distinct rows per bank and not just the number of lanes in a bank.
- All-lanes-same-word batches separate broadcast from conflict. Mixed read/write batches on one word show the read-before-write ordering inside a cycle.
- Same-word writes from every lane show which writer wins.
- Random batches over a narrow address window mix all of these cases.
- Empty batches, stalled responses and requests offered while the block is busy test the edges of the handshake.

// File: rtl/smem_arb_pkg.sv
package smem_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SERVE = 2'd1,
    ST_REPLY = 2'd2
  } arb_state_e;
endpackage

// File: rtl/smem_bank_pick.sv
// For one bank: find the lowest-numbered pending lane that maps here and
// report the row it names; that row is what the bank serves this cycle.
module smem_bank_pick #(
  parameter int LANES   = 32,
  parameter int BANKS   = 32,
  parameter int AW      = 10,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES*AW-1:0] addr_flat,
  output logic                hit,
  output logic [AW-$clog2(BANKS)-1:0] row
);
  localparam int BW = $clog2(BANKS);
  localparam int RW = AW - BW;

  always_comb begin
    hit = 1'b0;
    row = '0;
    for (int l = 0; l < LANES; l++) begin
      if (!hit && pend[l] &&
          addr_flat[l*AW +: BW] == BW'(BANK_ID)) begin
        hit = 1'b1;
        row = addr_flat[l*AW+BW +: RW];
      end
    end
  end
endmodule

// File: rtl/smem_bank.sv
// One single-ported bank: combinational read of the selected row, and a
// write on the clock edge taken from the highest served writing lane.
module smem_bank #(
  parameter int LANES   = 32,
  parameter int BANKS   = 32,
  parameter int AW      = 10,
  parameter int DW      = 32,
  parameter int BANK_ID = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  logic [AW-$clog2(BANKS)-1:0] row,
  input  logic [LANES-1:0]    served,
  input  logic [LANES-1:0]    we,
  input  logic [LANES*AW-1:0] addr_flat,
  input  logic [LANES*DW-1:0] wdata_flat,
  output logic [DW-1:0]       rdata
);
  localparam int BW   = $clog2(BANKS);
  localparam int RW   = AW - BW;
  localparam int ROWS = 1 << RW;

  logic [DW-1:0] cells [ROWS];
  logic          wen;
  logic [DW-1:0] wval;

  assign rdata = cells[row];

  // ascending scan: the last matching lane (highest index) wins
  always_comb begin
    wen  = 1'b0;
    wval = '0;
    for (int l = 0; l < LANES; l++) begin
      if (served[l] && we[l] &&
          addr_flat[l*AW +: BW] == BW'(BANK_ID)) begin
        wen  = 1'b1;
        wval = wdata_flat[l*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '0;
    end else if (hit && wen) begin
      cells[row] <= wval;
    end
  end
endmodule

// File: rtl/smem_conflict_arb.sv
module smem_conflict_arb
  import smem_arb_pkg::*;
#(
  parameter int LANES = 32,
  parameter int BANKS = 32,   // power of two
  parameter int AW    = 10,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [LANES-1:0]             req_lane_en,
  input  logic [LANES-1:0]             req_we,
  input  logic [LANES*AW-1:0]          req_addr,
  input  logic [LANES*DW-1:0]          req_wdata,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [LANES*DW-1:0]          rsp_rdata,
  output logic [$clog2(LANES+1)-1:0]   rsp_cycles
);
  localparam int BW = $clog2(BANKS);
  localparam int RW = AW - BW;
  localparam int CW = $clog2(LANES+1);

  arb_state_e          state_q;
  logic [LANES-1:0]    pend_q;
  logic [LANES-1:0]    we_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] wdata_q;
  logic [LANES*DW-1:0] rdata_q;
  logic [CW-1:0]       cnt_q;

  logic                busy;
  logic                accept;
  logic [LANES-1:0]    served;
  logic [LANES-1:0]    pend_nxt;
  logic                bank_hit [BANKS];
  logic [RW-1:0]       bank_row [BANKS];
  logic [DW-1:0]       bank_rd  [BANKS];

  assign busy      = (state_q == ST_SERVE);
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_REPLY);
  assign accept    = req_valid && req_ready;
  assign rsp_rdata = rdata_q;
  assign rsp_cycles = cnt_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    smem_bank_pick #(
      .LANES(LANES), .BANKS(BANKS), .AW(AW), .BANK_ID(b)
    ) u_pick (
      .pend      (pend_q),
      .addr_flat (addr_q),
      .hit       (bank_hit[b]),
      .row       (bank_row[b])
    );

    smem_bank #(
      .LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW), .BANK_ID(b)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (bank_hit[b]),
      .row        (bank_row[b]),
      .served     (served),
      .we         (we_q),
      .addr_flat  (addr_q),
      .wdata_flat (wdata_q),
      .rdata      (bank_rd[b])
    );
  end

  // a lane is served when its bank's chosen row equals its own row
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [BW-1:0] bk;
      bk = addr_q[l*AW +: BW];
      served[l] = busy && pend_q[l] && bank_hit[bk] &&
                  (bank_row[bk] == addr_q[l*AW+BW +: RW]);
    end
    pend_nxt = pend_q & ~served;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      we_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            pend_q  <= req_lane_en;
            we_q    <= req_we;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            rdata_q <= '0;
            cnt_q   <= '0;
            state_q <= (|req_lane_en) ? ST_SERVE : ST_REPLY;
          end
        end
        ST_SERVE: begin
          for (int l = 0; l < LANES; l++) begin
            if (served[l] && !we_q[l])
              rdata_q[l*DW +: DW] <= bank_rd[addr_q[l*AW +: BW]];
          end
          pend_q <= pend_nxt;
          cnt_q  <= cnt_q + CW'(1);
          if (pend_nxt == '0) state_q <= ST_REPLY;
        end
        ST_REPLY: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smem_arb_chk.sv
module smem_arb_chk #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [LANES-1:0]           req_lane_en,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [LANES*DW-1:0]        rsp_rdata,
  input logic [$clog2(LANES+1)-1:0] rsp_cycles,
  input logic                       busy,
  input logic [LANES-1:0]           pend_q
);
  AST_REPLY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R9

  AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_cycles))); // R10

  AST_CYCLES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cycles <= LANES)); // R3

  AST_EMPTY_BATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_lane_en == '0) |=>
      (rsp_valid && rsp_cycles == '0)); // R8

  AST_SERVE_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (((pend_q & ~$past(pend_q)) == '0) &&
              (pend_q != $past(pend_q)))); // R3
endmodule

bind smem_conflict_arb smem_arb_chk #(.LANES(LANES), .DW(DW)) u_arb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_lane_en (req_lane_en),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .rsp_cycles  (rsp_cycles),
  .busy        (busy),
  .pend_q      (pend_q)
);

// File: tb/smem_conflict_arb_test.sv
`timescale 1ns/1ps
module smem_conflict_arb_test;
  localparam int L  = 32;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int CW = 6;

  typedef struct packed {
    logic [L*DW-1:0] rd;
    logic [CW-1:0]   cyc;
    logic [7:0]      tag;   // requirement number for messages
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [L-1:0] req_lane_en = '0;
  logic [L-1:0] req_we = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic [L*DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [L*DW-1:0] rsp_rdata;
  logic [CW-1:0] rsp_cycles;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t sb_q[$];
  logic [DW-1:0] shadow [1 << AW];

  always #2.5 clk = ~clk;

  smem_conflict_arb uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_lane_en(req_lane_en), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_cycles(rsp_cycles)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: compute expectation from the requirements, push, then offer
  task automatic send(input logic [L-1:0] en, input logic [L-1:0] we,
                      input logic [L*AW-1:0] ad, input logic [L*DW-1:0] wd,
                      input logic [7:0] tag);
    exp_t e;
    int maxc;
    e.rd = '0;
    maxc = 0;
    for (int b = 0; b < 32; b++) begin
      int c;
      c = 0;
      for (int i = 0; i < L; i++) begin
        bit first;
        if (!en[i] || ad[i*AW +: 5] != 5'(b)) continue;
        first = 1;
        for (int j = 0; j < i; j++)
          if (en[j] && ad[j*AW +: AW] == ad[i*AW +: AW]) first = 0;
        if (first) c++;
      end
      if (c > maxc) maxc = c;
    end
    for (int i = 0; i < L; i++)
      if (en[i] && !we[i]) e.rd[i*DW +: DW] = shadow[ad[i*AW +: AW]];
    for (int i = 0; i < L; i++)
      if (en[i] && we[i]) shadow[ad[i*AW +: AW]] = wd[i*DW +: DW];
    e.cyc = CW'(maxc);
    e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk); #1;
    req_lane_en = en; req_we = we; req_addr = ad; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb_q.size() == 0) begin
        check(0, "R9 unexpected response", 1, 0);
      end else begin
        exp_t e;
        string tg;
        e = sb_q.pop_front();
        tg = $sformatf("R%0d", e.tag);
        check(rsp_cycles == e.cyc, {tg, " cycles"}, rsp_cycles, e.cyc);
        for (int i = 0; i < L; i++)
          check(rsp_rdata[i*DW +: DW] == e.rd[i*DW +: DW],
                $sformatf("%s lane %0d rdata", tg, i),
                rsp_rdata[i*DW +: DW], e.rd[i*DW +: DW]);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [L*AW-1:0] ad;
    logic [L*DW-1:0] wd;
    logic [CW-1:0]   held_c;
    logic [L*DW-1:0] held_d;
    for (int a = 0; a < (1 << AW); a++) shadow[a] = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);

    // R1/R2: unit stride reads of a cleared memory
    for (int i = 0; i < L; i++) ad[i*AW +: AW] = AW'(i + 64);
    send('1, '0, ad, '0, 8'd1);
    // R2/R5: unit stride writes, then read back
    for (int i = 0; i < L; i++) begin
      ad[i*AW +: AW] = AW'(i);
      wd[i*DW +: DW] = 32'hA500_0000 + 32'(i * 7);
    end
    send('1, '1, ad, wd, 8'd2);
    send('1, '0, ad, '0, 8'd5);
    // R3: stride 2 with offset 1 -> twofold conflict
    for (int i = 0; i < L; i++) ad[i*AW +: AW] = AW'(2 * i + 1);
    send('1, '0, ad, '0, 8'd3);
    // R4: broadcast read of one word
    for (int i = 0; i < L; i++) ad[i*AW +: AW] = AW'(7);
    send('1, '0, ad, '0, 8'd4);
    // R6: every lane writes word 100, then read it
    for (int i = 0; i < L; i++) begin
      ad[i*AW +: AW] = AW'(100);
      wd[i*DW +: DW] = 32'hC0DE_0000 + 32'(i);
    end
    send('1, '1, ad, wd, 8'd6);
    send(32'h1, '0, ad, '0, 8'd6);
    // R7: even lanes read word 5, odd lanes write word 5
    for (int i = 0; i < L; i++) begin
      ad[i*AW +: AW] = AW'(5);
      wd[i*DW +: DW] = 32'h7700_0000 + 32'(i);
    end
    send('1, 32'hAAAA_AAAA, ad, wd, 8'd7);
    send(32'h1, '0, ad, '0, 8'd7);
    // R8: empty batch, then sparse enables (disabled lanes read zero)
    for (int i = 0; i < L; i++) ad[i*AW +: AW] = AW'(i);
    send('0, '1, ad, '1, 8'd8);
    send(32'h0000_F00F, '0, ad, '0, 8'd8);

    // R3/R9: 32 rows of bank 3, while busy offer a write that must be ignored
    for (int i = 0; i < L; i++) begin
      ad[i*AW +: AW] = AW'(i * 32 + 3);
      wd[i*DW +: DW] = 32'h3300_0000 + 32'(i);
    end
    send('1, '1, ad, wd, 8'd3);
    req_lane_en = '1; req_we = '1; req_wdata = '1;
    for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = AW'(900);
    req_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R9 req_ready low while busy", req_ready, 0);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    drain();
    ad = '0;
    ad[AW-1:0] = AW'(900);
    send(32'h1, '0, ad, '0, 8'd9);
    drain();

    // R10: stall the response and watch it hold
    rsp_ready = 1'b0;
    for (int i = 0; i < L; i++) ad[i*AW +: AW] = AW'(i * 32 + 3);
    send('1, '0, ad, '0, 8'd10);
    while (!rsp_valid) @(negedge clk);
    held_c = rsp_cycles;
    held_d = rsp_rdata;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_cycles == held_c && rsp_rdata == held_d,
            "R10 response held", {rsp_valid, rsp_cycles}, {1'b1, held_c});
    end
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    drain();

    // random mixes over a narrow window: R3 R4 R6 R7
    for (int t = 0; t < 40; t++) begin
      logic [L-1:0] en, we;
      en = $urandom;
      we = $urandom;
      for (int i = 0; i < L; i++) begin
        ad[i*AW +: AW] = AW'($urandom_range(0, 127));
        wd[i*DW +: DW] = $urandom;
      end
      send(en, we, ad, wd, 8'd3);
    end
    drain();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule